// File: doc/BRIEF.md
# Checkerboard RAM Self-Test Sequencer

This block runs a self-test over one region of a single-port synchronous RAM that has a one-cycle read latency. A start pulse latches a base address, a word count and a fault-injection request. The block then drives the RAM through four passes, one access per clock. The first pass fills the region with a checkerboard of `0xA5` and `0x5A` bytes. The second pass reads the region back and compares each word. The third pass fills the region with the opposite checkerboard. The fourth pass reads and compares again. Across the two compare passes, every bit cell is seen holding both a one and a zero.

The result is a sticky error flag, which is cleared when a run starts. A one-cycle done pulse ends each run. The fault-injection request flips the least significant bit of every word that is read before it is compared. This lets a run prove that the error path can actually rise. The test overwrites the region, so the caller must save and restore the contents if they matter.

Top module: `ckb_ram_tester`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `ram_we_o` and `ram_re_o` are all 0.
- R2: A `start_i` sampled while `busy_o` is 0 is accepted. In the next cycle `busy_o` is 1 and `err_o` is 0, and `base_i`, `depth_i` and `inject_i` are captured at that edge.
- R3: Phase 0 (`phase_o`=0) issues one write per cycle to addresses `base + k`, for k = 0 up to depth-1, modulo 2^ADDR_W. The data is byte `0xA5` replicated across the word when k is even, and byte `0x5A` replicated when k is odd.
- R4: Phase 1 (`phase_o`=1) starts in the cycle after the last phase-0 write. It issues one read per cycle over the same addresses in ascending order.
- R5: Phase 2 (`phase_o`=2) starts in the cycle after the last phase-1 read. It writes the swapped pattern: `0x5A` replicated at even k and `0xA5` replicated at odd k. Within any write phase, consecutive words are bitwise complements of each other.
- R6: Phase 3 (`phase_o`=3) starts in the cycle after the last phase-2 write. It reads the same addresses in ascending order.
- R7: The data returned one cycle after each read is compared with the word that the preceding write phase stored there. A mismatch sets `err_o` one cycle later. `err_o` then stays set until the next accepted start.
- R8: When `inject_i` was 1 at the accepted start, bit 0 of every read word is inverted before the compare. A run with a nonzero depth therefore ends with `err_o` = 1.
- R9: Two cycles after the last phase-3 read, `busy_o` is 0 and `done_o` is 1 for exactly one cycle, and `err_o` holds the final result. A run of depth d lasts 4*d+2 cycles from the start edge to the done cycle.
- R10: A `start_i` pulse while `busy_o` is 1 has no effect on the access sequence or on the run length.
- R11: A start with `depth_i` = 0 makes no RAM access. It raises `done_o` two cycles after the start edge and leaves `err_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when idle |
| base_i | input | ADDR_W | First RAM address of the region |
| depth_i | input | ADDR_W+1 | Number of words to test (0 to 2^ADDR_W) |
| inject_i | input | 1 | Flip bit 0 of read data during this run |
| ram_rdata_i | input | DATA_W | RAM read data, valid one cycle after a read |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_wdata_o | output | DATA_W | RAM write data |
| ram_re_o | output | 1 | RAM read enable |
| phase_o | output | 2 | Current pass, 0 to 3 |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Sticky compare-failure flag |

## Verification
Any slip in the sequencer's counter or state shows at the RAM ports in the same cycle. The symptom is a skipped or repeated address, the wrong pattern polarity, or a phase change at the wrong point, and the cycle-by-cycle reference compare catches it at once. A fault in the compare stage only becomes visible one cycle after the read data returns, as an `err_o` value that differs from the bench's own compare. Runs with an injected bit flip and with a RAM fault planted in the bench show that `err_o` can rise. Clean runs that follow show that it is cleared again by the next start.

// File: rtl/ckb_pkg.sv
package ckb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_A,
    ST_RD_A,
    ST_WR_B,
    ST_RD_B,
    ST_DRAIN
  } ckb_state_e;

endpackage

// File: rtl/ckb_seq.sv
module ckb_seq
  import ckb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   depth_i,
  output ckb_state_e        state_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              accept_o,
  output logic              done_o
);

  localparam int CNT_W = ADDR_W + 1;

  ckb_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] depth_q;
  logic [ADDR_W-1:0] base_q;
  logic              last_w;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign last_w   = (cnt_q == depth_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      depth_q <= '0;
      base_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= (state_q == ST_DRAIN);
      case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            base_q  <= base_i;
            depth_q <= depth_i;
            cnt_q   <= '0;
            state_q <= (depth_i == '0) ? ST_DRAIN : ST_WR_A;
          end
        end
        ST_WR_A, ST_RD_A, ST_WR_B: begin
          if (last_w) begin
            cnt_q   <= '0;
            state_q <= (state_q == ST_WR_A) ? ST_RD_A :
                       (state_q == ST_RD_A) ? ST_WR_B : ST_RD_B;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RD_B: begin
          if (last_w) begin
            cnt_q   <= '0;
            state_q <= ST_DRAIN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign idx_o   = cnt_q[ADDR_W-1:0];
  assign base_o  = base_q;

endmodule

// File: rtl/ckb_cmp.sv
module ckb_cmp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              inject_i,
  input  logic              rd_issue_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              miss_o,
  output logic              err_o
);

  logic              pend_q;
  logic              inj_q;
  logic [DATA_W-1:0] exp_q;
  logic [DATA_W-1:0] seen_w;

  assign seen_w = rdata_i ^ {{(DATA_W-1){1'b0}}, inj_q};
  assign miss_o = pend_q && (seen_w != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      inj_q  <= 1'b0;
      exp_q  <= '0;
      err_o  <= 1'b0;
    end else begin
      pend_q <= rd_issue_i;
      exp_q  <= exp_i;
      if (clear_i) begin
        inj_q <= inject_i;
        err_o <= 1'b0;
      end else if (miss_o) begin
        err_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ckb_ram_tester.sv
module ckb_ram_tester
  import ckb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   depth_i,
  input  logic              inject_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_re_o,
  output logic [1:0]        phase_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int NBYTES = DATA_W / 8;

  function automatic logic [DATA_W-1:0] fill_word(input logic [7:0] b);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < NBYTES; i++) w[i*8 +: 8] = b;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] word_pattern(input logic second, input logic odd);
    return fill_word((second ^ odd) ? 8'h5A : 8'hA5);
  endfunction

  ckb_state_e        state_w;
  logic [ADDR_W-1:0] idx_w;
  logic [ADDR_W-1:0] base_w;
  logic              accept_w;
  logic              second_w;
  logic              miss_w;
  logic [DATA_W-1:0] pattern_w;

  ckb_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .base_i   (base_i),
    .depth_i  (depth_i),
    .state_o  (state_w),
    .idx_o    (idx_w),
    .base_o   (base_w),
    .accept_o (accept_w),
    .done_o   (done_o)
  );

  assign second_w  = (state_w == ST_WR_B) || (state_w == ST_RD_B);
  assign pattern_w = word_pattern(second_w, idx_w[0]);

  assign ram_we_o    = (state_w == ST_WR_A) || (state_w == ST_WR_B);
  assign ram_re_o    = (state_w == ST_RD_A) || (state_w == ST_RD_B);
  assign ram_addr_o  = base_w + idx_w;
  assign ram_wdata_o = ram_we_o ? pattern_w : '0;
  assign busy_o      = (state_w != ST_IDLE);

  always_comb begin
    case (state_w)
      ST_RD_A:           phase_o = 2'd1;
      ST_WR_B:           phase_o = 2'd2;
      ST_RD_B, ST_DRAIN: phase_o = 2'd3;
      default:           phase_o = 2'd0;
    endcase
  end

  ckb_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (accept_w),
    .inject_i   (inject_i),
    .rd_issue_i (ram_re_o),
    .exp_i      (pattern_w),
    .rdata_i    (ram_rdata_i),
    .miss_o     (miss_w),
    .err_o      (err_o)
  );

endmodule

// File: rtl/ckb_ram_tester_chk.sv
module ckb_ram_tester_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_we_o,
  input logic [DATA_W-1:0] ram_wdata_o,
  input logic [1:0]        phase_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              miss_w
);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !err_o));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o && $past(ram_we_o) && phase_o == $past(phase_o))
      |-> ram_addr_o == $past(ram_addr_o) + 1'b1);

  // R5
  wdata_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we_o && $past(ram_we_o) && phase_o == $past(phase_o))
      |-> ram_wdata_o == ~$past(ram_wdata_o));

  // R6
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && phase_o != $past(phase_o))
      |-> phase_o == $past(phase_o) + 2'd1);

  // R7
  miss_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_w |=> err_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !(start_i && !busy_o)) |=> err_o);

  // R9
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o ##1 !done_o));

endmodule

bind ckb_ram_tester ckb_ram_tester_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .ram_addr_o  (ram_addr_o),
  .ram_we_o    (ram_we_o),
  .ram_wdata_o (ram_wdata_o),
  .phase_o     (phase_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .miss_w      (miss_w)
);

// File: tb/test_ckb_ram_tester.sv
module test_ckb_ram_tester;

  localparam int DW = 32;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [AW:0]   depth = '0;
  logic          inject = 1'b0;
  logic [DW-1:0] rdata;
  logic [AW-1:0] addr;
  logic          we, re, busy, done, err;
  logic [DW-1:0] wdata;
  logic [1:0]    phase;

  always #5 clk = ~clk;

  ckb_ram_tester #(.DATA_W(DW), .ADDR_W(AW)) i_ckb_ram_tester (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .depth_i(depth),
    .inject_i(inject), .ram_rdata_i(rdata), .ram_addr_o(addr), .ram_we_o(we),
    .ram_wdata_o(wdata), .ram_re_o(re), .phase_o(phase), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  // RAM model with an optional planted read fault
  logic [DW-1:0] mem [NW];
  logic          fault_on = 1'b0;
  logic [AW-1:0] fault_addr = '0;
  initial rdata = '0;
  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr] ^ ((fault_on && addr == fault_addr) ? DW'(4) : DW'(0));
  end

  typedef struct {
    bit busy; bit we; bit re; bit done;
    int ph; int adr; logic [DW-1:0] dat;
  } cyc_t;

  cyc_t          q[$];
  int            checks = 0;
  int            fails = 0;
  bit            running = 0;
  bit            m_err = 0;
  bit            m_inj = 0;
  bit            pend = 0;
  logic [DW-1:0] pend_exp = '0;

  function automatic logic [DW-1:0] fill(bit second, int k);
    logic [7:0] b;
    b = (((k % 2) == 1) != second) ? 8'h5A : 8'hA5;
    return {(DW/8){b}};
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic plan_run(int b, int d);
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < d; k++)
        q.push_back('{busy:1, we:(p % 2 == 0), re:(p % 2 == 1), done:0,
                      ph:p, adr:(b + k) % NW, dat:fill(p >= 2, k)});
    q.push_back('{busy:1, we:0, re:0, done:0, ph:0, adr:0, dat:'0});
    q.push_back('{busy:0, we:0, re:0, done:1, ph:0, adr:0, dat:'0});
  endtask

  // cycle-by-cycle reference compare
  always @(negedge clk) begin
    if (rst_n && running) begin
      cyc_t  c;
      string tg;
      bit    idle_now;
      if (q.size() > 0) c = q[0];
      else c = '{busy:0, we:0, re:0, done:0, ph:0, adr:0, dat:'0};
      tg = (c.ph == 0) ? "R3" : (c.ph == 1) ? "R4" : (c.ph == 2) ? "R5" : "R6";
      chk("R2 busy", DW'(busy), DW'(c.busy));
      chk("R9 done", DW'(done), DW'(c.done));
      chk({tg, " we"}, DW'(we), DW'(c.we));
      chk({tg, " re"}, DW'(re), DW'(c.re));
      if (c.we || c.re) begin
        chk({tg, " addr"}, DW'(addr), DW'(c.adr));
        chk({tg, " phase"}, DW'(phase), DW'(c.ph));
      end
      if (c.we) chk({tg, " wdata"}, wdata, c.dat);
      chk("R7 err", DW'(err), DW'(m_err));
      if (pend && ((rdata ^ DW'(m_inj)) !== pend_exp)) m_err = 1;
      pend     = c.re;
      pend_exp = c.dat;
      idle_now = !c.busy;
      if (q.size() > 0) void'(q.pop_front());
      if (start && idle_now) begin
        m_err = 0;
        m_inj = inject;
        plan_run(int'(base), int'(depth));
      end
    end
  end

  task automatic run(int b, int d, bit inj, output int cyc);
    @(posedge clk); #2;
    start = 1; base = AW'(b); depth = (AW+1)'(d); inject = inj;
    @(posedge clk); #2;
    start = 0; inject = 0;
    cyc = 1;
    while (!done) begin
      @(posedge clk); #2;
      cyc++;
    end
  endtask

  task automatic finish_sim();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  initial begin
    int cyc;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 busy", DW'(busy), '0);
    chk("R1 done", DW'(done), '0);
    chk("R1 err", DW'(err), '0);
    chk("R1 we", DW'(we), '0);
    chk("R1 re", DW'(re), '0);
    rst_n = 1;
    running = 1;
    @(posedge clk); #2;
    chk("R1 idle after release", DW'(busy), '0);

    run(0, 8, 0, cyc);
    chk("R7 clean run err", DW'(err), '0);
    chk("R9 run length d=8", DW'(cyc), DW'(4*8+2));

    run(NW - 4, 5, 0, cyc);
    chk("R3 wrap run err", DW'(err), '0);

    run(2, 4, 1, cyc);
    chk("R8 injected flip sets err", DW'(err), DW'(1));

    run(2, 4, 0, cyc);
    chk("R2 err cleared by new start", DW'(err), '0);

    fault_on = 1; fault_addr = AW'(3);
    run(0, 8, 0, cyc);
    chk("R7 planted fault sets err", DW'(err), DW'(1));
    fault_on = 0;

    fork
      run(5, 10, 0, cyc);
      begin
        repeat (7) @(posedge clk);
        #2; start = 1; base = AW'(30); depth = (AW+1)'(3);
        @(posedge clk); #2; start = 0;
      end
    join
    chk("R10 start while busy ignored", DW'(cyc), DW'(4*10+2));

    run(9, 0, 0, cyc);
    chk("R11 zero depth length", DW'(cyc), DW'(2));
    chk("R11 zero depth err", DW'(err), '0);

    run(17, 1, 0, cyc);
    chk("R9 run length d=1", DW'(cyc), DW'(6));

    run(0, NW, 0, cyc);
    chk("R9 full region length", DW'(cyc), DW'(4*NW+2));
    chk("R7 full region err", DW'(err), '0);

    repeat (3) @(posedge clk);
    finish_sim();
  end

endmodule